// File: doc/BRIEF.md
# Capture-Compare Timer Channel

A single 16-bit timer channel steered by one control word held in a small register port. The counter's rate comes from a power-of-two prescaler on the system clock, a double-rate setting, or the rising edges of an external event input. The same external input also serves as the capture input.

The control word picks one of eight functions. The first is plain free-running counting. Two are compare functions that drive an output pin: one toggles the pin on a match and the other pulses it high for one clock. The other five are capture functions, which sample the counter on a falling edge, on a rising edge, or on every 2nd, 4th or 8th rising edge. A match or a capture sets an interrupt latch. Software releases the latch with a two-write handshake on a dedicated control bit. A control bit can also freeze the counter while the processor is halted for debug.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the control word and the capture register are 0, the counter is 0, the compare register is 0xFFFF, and `cmp_out` and `irq` are low.
- R2: The register port uses address 0 for control, with run enable at bit 15, function at bits 14:12, debug freeze at bit 11, interrupt release at bit 10 and rate select at bits 9:6. Address 1 holds the compare value in bits 15:0. Address 2 reads the counter and address 3 reads the capture register. Bits 31:16, and bits 5:0 of the control word, read as 0. Writes to addresses 2 and 3 have no effect.
- R3: While run enable is 0 the counter holds its value.
- R4: With run enable set, the rate select sets the counter value N clocks after the enabling write. Code 0 gives 2N. Codes 1 to 8 give floor(N / 2^(code-1)). Codes 9 to 14 leave the counter at 0.
- R5: Rate select 15 advances the counter by 1 for each rising edge of `evt_in`. An edge driven between clock edges is reflected in the counter on the third rising clock edge after it, and falling edges do not count.
- R6: When debug freeze is 1 and `dbg_halt` is high, the counter holds. When debug freeze is 0, `dbg_halt` has no effect.
- R7: In function 001 (toggle compare), a count step taken while the counter equals the compare value reloads the counter to 0, inverts `cmp_out` and sets `irq`.
- R8: In function 010 (pulse compare), the same match reloads the counter and sets `irq`, and `cmp_out` is high for exactly the one clock that follows the match.
- R9: Function 011 captures the counter into the capture register on a synchronized falling edge of `evt_in` and ignores rising edges. Function 100 captures on rising edges. Each capture sets `irq`, and only while run enable is 1.
- R10: Functions 101, 110 and 111 capture on every 2nd, 4th and 8th rising edge. The edge tally restarts from zero whenever the function field changes.
- R11: `irq` is cleared only by a control write with bit 10 = 0 that follows a control write with bit 10 = 1. Writing 1 alone, or writing 0 without a prior 1, leaves it set.
- R12: In function 000 the counter wraps from its top value to 0, and neither `irq` nor `cmp_out` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | External event / capture input, asynchronous |
| dbg_halt | input | 1 | High while the processor is halted for debug |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| count_o | output | 16 | Current counter value |
| capture_o | output | 16 | Capture register |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt latch |

## Verification
The bench uses the default parameters. With a 16-bit counter, the wrap at double rate is reached in 32768 clocks. A 7-bit prescaler lets the sweep cover every divisor from 1 to 128 over a 300-clock window. Two synchronizer stages give an edge-to-effect latency of three clocks, and the bench checks that latency exactly. The compare periods, pulse positions and capture tallies are checked clock by clock against closed-form expressions, including a function switch made partway through a tally.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int CTRL_LSB = 6;
  localparam int REG_AW   = 2;
  localparam int EDGE_W   = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_CMP  = 2'd1;
  localparam logic [REG_AW-1:0] A_CNT  = 2'd2;
  localparam logic [REG_AW-1:0] A_CAP  = 2'd3;

  localparam logic [3:0] SEL_DOUBLE = 4'd0;
  localparam logic [3:0] SEL_EXT    = 4'd15;

  typedef enum logic [2:0] {
    CC_NONE     = 3'd0,
    CC_TOGGLE   = 3'd1,
    CC_PULSE    = 3'd2,
    CC_CAP_FALL = 3'd3,
    CC_CAP_RISE = 3'd4,
    CC_CAP_R2   = 3'd5,
    CC_CAP_R4   = 3'd6,
    CC_CAP_R8   = 3'd7
  } cc_mode_e;

  // Control word, stored as bits 15:6 of the register
  typedef struct packed {
    logic       en;
    cc_mode_e   mode;
    logic       halt_stop;
    logic       irq_rel;
    logic [3:0] clk_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Prescaler codes 1..8 divide by 2^(code-1)
  function automatic logic sel_is_div(input logic [3:0] sel);
    return (sel >= 4'd1) && (sel <= 4'd8);
  endfunction

  // Low bits of the prescaler that must all be set for a tick
  function automatic logic [15:0] div_mask(input logic [3:0] sel);
    logic [15:0] one;
    one = 16'd1;
    if (sel_is_div(sel)) return (one << (sel - 4'd1)) - one;
    return '0;
  endfunction

  function automatic logic [1:0] step_of(input logic [3:0] sel);
    return (sel == SEL_DOUBLE) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic is_compare(input cc_mode_e m);
    return (m == CC_TOGGLE) || (m == CC_PULSE);
  endfunction

  function automatic logic is_nth_edge(input cc_mode_e m);
    return (m == CC_CAP_R2) || (m == CC_CAP_R4) || (m == CC_CAP_R8);
  endfunction

  // Edge tally value at which a divide-by-N capture fires (N-1)
  function automatic logic [EDGE_W-1:0] edge_goal(input cc_mode_e m);
    case (m)
      CC_CAP_R2: return 3'd1;
      CC_CAP_R4: return 3'd3;
      CC_CAP_R8: return 3'd7;
      default:   return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cct_prescale.sv
module cct_prescale
  import cct_pkg::*;
#(
  parameter int PRE_W = 7   // must cover the largest divisor (128)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] clk_sel,
  input  logic       ext_rise,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             div_hit;

  assign mask    = PRE_W'(div_mask(clk_sel));
  assign div_hit = ((pre_q & mask) == mask);

  // Phase counter restarts whenever counting is paused
  always_ff @(posedge clk) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= pre_q + PRE_W'(1);
  end

  always_comb begin
    tick = 1'b0;
    if (run) begin
      if (sel_is_div(clk_sel))        tick = div_hit;
      else if (clk_sel == SEL_DOUBLE) tick = 1'b1;
      else if (clk_sel == SEL_EXT)    tick = ext_rise;
    end
  end

  // R4: a divided rate never ticks on two consecutive clocks
  a_r4_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_is_div(clk_sel) && (clk_sel != 4'd1))
      |=> (!tick || (clk_sel != $past(clk_sel))));

endmodule

// File: rtl/cct_evt_edge.sv
module cct_evt_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   synced;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= evt_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= synced;
  end

  assign rise = synced & ~last_q;
  assign fall = ~synced & last_q;

  // R5: an edge report lasts a single clock
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  // R9: falling edges are reported once as well
  a_r9_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/cct_capture.sv
module cct_capture
  import cct_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  cc_mode_e mode,
  input  logic     rise,
  input  logic     fall,
  output logic     cap_evt
);

  cc_mode_e          mode_q;
  logic [EDGE_W-1:0] ecnt_q;
  logic [EDGE_W-1:0] ecnt_eff;
  logic [EDGE_W-1:0] goal;
  logic              nth;
  logic              tally_hit;

  assign nth       = is_nth_edge(mode);
  assign goal      = edge_goal(mode);
  // A function change restarts the tally in the same cycle
  assign ecnt_eff  = (mode != mode_q) ? '0 : ecnt_q;
  assign tally_hit = (ecnt_eff == goal);

  always_comb begin
    case (mode)
      CC_CAP_FALL:                    cap_evt = en & fall;
      CC_CAP_RISE:                    cap_evt = en & rise;
      CC_CAP_R2, CC_CAP_R4, CC_CAP_R8: cap_evt = en & rise & tally_hit;
      default:                        cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= CC_NONE;
      ecnt_q <= '0;
    end else begin
      mode_q <= mode;
      if (nth && en && rise) ecnt_q <= tally_hit ? '0 : EDGE_W'(ecnt_eff + EDGE_W'(1));
      else                   ecnt_q <= ecnt_eff;
    end
  end

  // R10: with an unchanged function the tally stays below its target
  a_r10_tally_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (nth && (mode == mode_q)) |-> (ecnt_q <= goal));

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              dbg_halt,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  capture_o,
  output logic              cmp_out,
  output logic              irq
);

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_wr;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cap_q;
  logic             out_q;
  logic             irq_q;

  logic             wr_ctrl;
  logic             wr_cmp;
  logic             rel_evt;
  logic             run;
  logic             tick;
  logic             ext_rise;
  logic             ext_fall;
  logic             cap_evt;
  logic             cmp_match;
  logic             unused_wbits;

  assign wr_ctrl      = reg_we && (reg_addr == A_CTRL);
  assign wr_cmp       = reg_we && (reg_addr == A_CMP);
  assign ctrl_wr      = ctrl_t'(reg_wdata[CTRL_LSB +: CTRL_W]);
  assign unused_wbits = ^reg_wdata[DATA_W-1:CNT_W];

  // Interrupt release: a write of 0 to the release bit after a stored 1
  assign rel_evt = wr_ctrl && ctrl_q.irq_rel && !ctrl_wr.irq_rel;

  assign run = ctrl_q.en && !(ctrl_q.halt_stop && dbg_halt);

  cct_evt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .rise   (ext_rise),
    .fall   (ext_fall)
  );

  cct_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clk_sel  (ctrl_q.clk_sel),
    .ext_rise (ext_rise),
    .tick     (tick)
  );

  cct_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.en),
    .mode    (ctrl_q.mode),
    .rise    (ext_rise),
    .fall    (ext_fall),
    .cap_evt (cap_evt)
  );

  assign cmp_match = is_compare(ctrl_q.mode) && tick && (count_q == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_wr;
      if (wr_cmp)  cmp_q  <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         count_q <= '0;
    else if (cmp_match) count_q <= '0;
    else if (tick)      count_q <= count_q + CNT_W'(step_of(ctrl_q.clk_sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= count_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      case (ctrl_q.mode)
        CC_TOGGLE: if (cmp_match) out_q <= ~out_q;
        CC_PULSE:  out_q <= cmp_match;
        default:   out_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    irq_q <= 1'b0;
    else if (cmp_match || cap_evt) irq_q <= 1'b1;
    else if (rel_evt)              irq_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_LSB +: CTRL_W] = ctrl_q;
      A_CMP:   reg_rdata[CNT_W-1:0] = cmp_q;
      A_CNT:   reg_rdata[CNT_W-1:0] = count_q;
      default: reg_rdata[CNT_W-1:0] = cap_q;
    endcase
  end

  assign count_o   = count_q;
  assign capture_o = cap_q;
  assign cmp_out   = out_q;
  assign irq       = irq_q;

  // R3: a disabled channel keeps its count
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> (count_q == $past(count_q)));

  // R7: a compare match restarts the count from zero
  a_r7_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |=> (count_q == '0));

  // R7: toggle compare inverts the pin on a match
  a_r7_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_match && (ctrl_q.mode == CC_TOGGLE)) |=> (cmp_out != $past(cmp_out)));

  // R8: a pulse lasts one clock unless a zero compare value re-matches
  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_out && (ctrl_q.mode == CC_PULSE) && (cmp_q != '0))
      |=> (!cmp_out || (ctrl_q.mode != CC_PULSE)));

  // R11: the latch only falls after the release handshake
  a_r11_release_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rel_evt));

  // R12: plain counting never raises the interrupt
  a_r12_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q.mode == CC_NONE) && !irq) |=> !irq);

endmodule

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_in = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [15:0] count_o;
  logic [15:0] capture_o;
  logic        cmp_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  capcmp_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .dbg_halt  (dbg_halt),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .count_o   (count_o),
    .capture_o (capture_o),
    .cmp_out   (cmp_out),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt_in = 1'b0; dbg_halt = 1'b0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a falling edge; returns at the falling edge after the write
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic evt_pulse();
    evt_in = 1'b1;
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl_word(input bit en, input int mode, input bit frz,
                                            input bit rel, input int sel);
    return {16'd0, en, 3'(mode), frz, rel, 4'(sel), 6'd0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] f;
    logic [15:0] g;
    do_reset();

    // R1 reset state
    check("R1 count", 32'(count_o), 0);
    check("R1 capture", 32'(capture_o), 0);
    check("R1 cmp_out", 32'(cmp_out), 0);
    check("R1 irq", 32'(irq), 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 compare", v, 32'h0000_FFFF);

    // R2 register map, reserved bits, read-only registers
    @(negedge clk);
    wr(2'd0, 32'hFFFF_7FFF);
    rd(2'd0, v); check("R2 ctrl fields", v, 32'h0000_7FC0);
    wr(2'd0, 32'h0);
    rd(2'd0, v); check("R2 ctrl cleared", v, 0);
    wr(2'd1, 32'hABCD_1234);
    rd(2'd1, v); check("R2 compare low half", v, 32'h0000_1234);
    wr(2'd3, 32'h0000_5555);
    rd(2'd3, v); check("R2 capture read-only", v, 0);
    wr(2'd2, 32'h0000_7777);
    rd(2'd2, v); check("R2 counter read-only", v, 0);

    // R3 enable clear with a fast rate selected
    wr(2'd0, ctrl_word(0, 0, 0, 0, 1));
    repeat (10) @(negedge clk);
    check("R3 disabled count", 32'(count_o), 0);

    // R4 rate select sweep
    for (int s = 0; s < 15; s++) begin
      int exp;
      do_reset();
      wr(2'd0, ctrl_word(1, 0, 0, 0, s));
      repeat (300) @(negedge clk);
      if (s == 0)      exp = 600;
      else if (s <= 8) exp = 300 >> (s - 1);
      else             exp = 0;
      check($sformatf("R4 sel %0d", s), 32'(count_o), 32'(exp));
      if (s == 1) begin
        wr(2'd0, ctrl_word(0, 0, 0, 0, 1));
        f = count_o;
        repeat (20) @(negedge clk);
        check("R3 hold after disable", 32'(count_o), 32'(f));
        rd(2'd2, v); check("R2 counter readback", v, 32'(f));
      end
    end

    // R5 external event counting and latency
    do_reset();
    wr(2'd0, ctrl_word(1, 0, 0, 0, 15));
    evt_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 before latency", 32'(count_o), 0);
    @(negedge clk);
    check("R5 third edge", 32'(count_o), 1);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 fall ignored", 32'(count_o), 1);
    for (int k = 0; k < 4; k++) evt_pulse();
    check("R5 five events", 32'(count_o), 5);

    // R6 debug freeze
    do_reset();
    dbg_halt = 1'b1;
    wr(2'd0, ctrl_word(1, 0, 1, 0, 1));
    repeat (20) @(negedge clk);
    check("R6 frozen", 32'(count_o), 0);
    dbg_halt = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 resumed", 32'(count_o), 10);
    do_reset();
    dbg_halt = 1'b1;
    wr(2'd0, ctrl_word(1, 0, 0, 0, 1));
    repeat (10) @(negedge clk);
    check("R6 freeze bit clear", 32'(count_o), 10);
    dbg_halt = 1'b0;

    // R7 toggle compare, period compare+1
    do_reset();
    wr(2'd1, 32'd4);
    wr(2'd0, ctrl_word(1, 1, 0, 0, 1));
    for (int n = 1; n <= 22; n++) begin
      @(negedge clk);
      check($sformatf("R7 count n=%0d", n), 32'(count_o), 32'(n % 5));
      check($sformatf("R7 pin n=%0d", n), 32'(cmp_out), 32'((n / 5) % 2));
      check($sformatf("R7 irq n=%0d", n), 32'(irq), 32'(n >= 5));
    end

    // R11 release handshake
    wr(2'd0, ctrl_word(0, 1, 0, 0, 1));
    check("R11 zero without one", 32'(irq), 1);
    wr(2'd0, ctrl_word(0, 1, 0, 1, 1));
    check("R11 one alone", 32'(irq), 1);
    wr(2'd0, ctrl_word(0, 1, 0, 0, 1));
    check("R11 one then zero", 32'(irq), 0);
    repeat (5) @(negedge clk);
    check("R11 stays clear", 32'(irq), 0);

    // R8 pulse compare at full rate
    do_reset();
    wr(2'd1, 32'd3);
    wr(2'd0, ctrl_word(1, 2, 0, 0, 1));
    for (int n = 1; n <= 17; n++) begin
      @(negedge clk);
      check($sformatf("R8 count n=%0d", n), 32'(count_o), 32'(n % 4));
      check($sformatf("R8 pulse n=%0d", n), 32'(cmp_out), 32'((n % 4) == 0));
    end
    // R8 pulse compare with divide by 2
    do_reset();
    wr(2'd1, 32'd2);
    wr(2'd0, ctrl_word(1, 2, 0, 0, 2));
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      check($sformatf("R8 div2 count n=%0d", n), 32'(count_o), 32'((n % 6) / 2));
      check($sformatf("R8 div2 pulse n=%0d", n), 32'(cmp_out), 32'((n % 6) == 0));
    end

    // R9 falling and rising edge capture
    do_reset();
    wr(2'd0, ctrl_word(1, 0, 0, 0, 1));
    repeat (7) @(negedge clk);
    wr(2'd0, ctrl_word(1, 3, 0, 0, 10));
    f = count_o;
    evt_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 rise ignored in fall mode", 32'(capture_o), 0);
    check("R9 no irq on rise", 32'(irq), 0);
    evt_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 fall before latency", 32'(capture_o), 0);
    @(negedge clk);
    check("R9 fall capture", 32'(capture_o), 32'(f));
    check("R9 fall irq", 32'(irq), 1);
    wr(2'd0, ctrl_word(1, 0, 0, 1, 1));
    repeat (5) @(negedge clk);
    wr(2'd0, ctrl_word(1, 4, 0, 0, 10));
    g = count_o;
    check("R9 irq released", 32'(irq), 0);
    evt_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 rise capture", 32'(capture_o), 32'(g));
    check("R9 rise irq", 32'(irq), 1);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);

    // R10 divide-by-N capture
    for (int m = 5; m <= 7; m++) begin
      int nn;
      nn = 1 << (m - 4);
      do_reset();
      wr(2'd0, ctrl_word(1, m, 0, 0, 10));
      for (int k = 1; k <= nn; k++) begin
        evt_pulse();
        check($sformatf("R10 mode %0d edge %0d", m, k), 32'(irq), 32'(k == nn));
      end
    end
    // R10 tally restarts on a function change
    do_reset();
    wr(2'd0, ctrl_word(1, 7, 0, 0, 10));
    for (int k = 0; k < 3; k++) evt_pulse();
    check("R10 partial tally", 32'(irq), 0);
    wr(2'd0, ctrl_word(1, 6, 0, 0, 10));
    evt_pulse();
    check("R10 restart first edge", 32'(irq), 0);
    evt_pulse(); evt_pulse();
    check("R10 restart third edge", 32'(irq), 0);
    evt_pulse();
    check("R10 restart fourth edge", 32'(irq), 1);

    // R12 wrap in plain counting at double rate
    do_reset();
    wr(2'd0, ctrl_word(1, 0, 0, 0, 0));
    repeat (32767) @(negedge clk);
    check("R12 top value", 32'(count_o), 32'hFFFE);
    @(negedge clk);
    check("R12 wrapped", 32'(count_o), 0);
    check("R12 no irq", 32'(irq), 0);
    check("R12 pin low", 32'(cmp_out), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule